// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block plays back a list of DRAM commands that software has stored, and it does this before the memory is opened to normal traffic. Software fills a table of command slots through a plain indexed write port. Each slot has two words. The command word is placed on the DRAM command bus as it is. The parameter word carries an 11-bit address or mode value and a wait that follows the command. The wait is stored as the number of cycles wanted minus two.

Software then writes the issue register. This register holds a valid flag and the index of the last slot to play, and software also sets the init-start control bit. The sequencer then issues slots 0 through the last index in ascending order, with exactly one issue cycle per slot. Each command is followed by its programmed gap. After the gap of the final slot the valid flag clears by itself, and software polls it to see that the list has finished. Normal operation is enabled only when both init-start and init-done are set.

A typical list is the DRAM power-up order, which has twelve entries. It starts with a long clock-enable NOP. Then come precharge-all, the extended mode registers 2, 3 and 1, and the mode register with DLL reset. After those come precharge-all, two refreshes, and the mode register without DLL reset. The list ends with extended mode register 1 at its driver-calibration default and then at its driver-calibration exit setting. The command output has no back-pressure, because the DRAM accepts a command on every cycle. For this reason the command bus is a plain one-cycle strobe and not a valid/ready stream.

Top module: `dram_init_seq`

## Requirements
- R1: After reset, the outputs are `busy`=0, `issue_valid`=0, `normal_en`=0 and `dram_cmd_strobe`=0. At the same time `dram_cmd` equals the NOP word (default 0) and `dram_addr` is 0.
- R2: A slot write with `slot_sel`=0 stores the command word and a write with `slot_sel`=1 stores the parameter word, each in slot `slot_idx`. A stored word keeps its value until that same word is written again, and a replay always uses the latest contents.
- R3: While a slot is being issued, `dram_addr` shows bits 10:0 of its parameter word. Let W be bits 31:11 of that word. The next strobe comes exactly W+2 cycles after this strobe, so W=0 gives the minimum spacing of 2 cycles.
- R4: When the last-index value is N, slots 0 through N are issued in ascending order, with one strobe for each slot, which makes N+1 strobes. N=0 issues a single command.
- R5: Exactly W_N+2 cycles after the strobe of slot N, `issue_valid` clears by itself and `busy` falls in that same cycle. `busy` stays high from the first issue until that point.
- R6: A replay starts only when `issue_valid` and the init-start bit are both set. If the valid flag is set while init-start is clear, no command is issued.
- R7: On every cycle that is not a strobe cycle, `dram_cmd` equals the NOP word and `dram_addr` is 0.
- R8: `normal_en` is high exactly when both the init-start bit and the init-done bit are set. A control write (`ctl_we`) loads both bits.
- R9: Writes to the issue register while `busy` is high are ignored. The running list finishes with its original length and `issue_valid` stays set until the list is complete.
- R10: The twelve-entry power-up list (N=11) plays back completely, and each command appears with its own address and gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_we | input | 1 | Slot write strobe |
| slot_idx | input | IDX_W | Slot being written |
| slot_sel | input | 1 | Word select: 0 = command word, 1 = parameter word |
| slot_wdata | input | 32 | Slot write data |
| issue_we | input | 1 | Issue register write strobe |
| issue_valid_in | input | 1 | Valid flag value to write |
| issue_last | input | IDX_W | Index of the last slot to replay |
| ctl_we | input | 1 | Control register write strobe |
| ctl_start | input | 1 | Init-start bit value |
| ctl_done | input | 1 | Init-done bit value |
| dram_cmd | output | 32 | DRAM command bus (NOP when not issuing) |
| dram_addr | output | 11 | DRAM address/mode bus |
| dram_cmd_strobe | output | 1 | High for the single cycle in which a slot is issued |
| issue_valid | output | 1 | Valid flag; clears by itself when the list completes |
| busy | output | 1 | Replay in progress |
| normal_en | output | 1 | Normal operation permitted |

## Verification
The main function is tried with three patterns, and each one separates a different kind of fault. The first is the full twelve-entry power-up list with mixed gaps, which shows off-by-one errors in the gap. The second is a three-slot list that receives an issue write partway through, which shows whether the length and valid flag are protected once the list has started. The third is a pair of minimum-gap lists, N=0 and N=1 with W=0, which show whether the two-cycle floor and the end-of-list index compare are correct. Each strobe is checked for its command word, address and spacing to the previous strobe. After the last strobe the bench measures the delay until the valid flag clears and checks that `busy` falls with it. Every cycle in between is checked for the NOP word.

// File: rtl/dis_pkg.sv
package dis_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 11;
  localparam int WAIT_W = WORD_W - ADDR_W;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_GAP   = 2'd2
  } sq_state_t;
endpackage

// File: rtl/dis_slot_bank.sv
module dis_slot_bank #(
  parameter int SLOTS = 16,
  parameter int IDX_W = $clog2(SLOTS),
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_cmd,
  output logic [WORD_W-1:0] rd_param
);
  logic [WORD_W-1:0] cmd_mem   [SLOTS];
  logic [WORD_W-1:0] param_mem [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_mem[s]   <= '0;
        param_mem[s] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        if (wr_sel) param_mem[s] <= wr_data;
        else        cmd_mem[s]   <= wr_data;
      end
    end
  end

  assign rd_cmd   = cmd_mem[rd_idx];
  assign rd_param = param_mem[rd_idx];
endmodule

// File: rtl/dis_gap_timer.sv
module dis_gap_timer #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: a loaded gap shortens by one per cycle until it runs out
  assert_gap_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/dis_replay_ctl.sv
module dis_replay_ctl
  import dis_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_we,
  input  logic             issue_valid_in,
  input  logic [IDX_W-1:0] issue_last,
  input  logic             start_q,
  input  logic             gap_expired,
  output logic             busy,
  output logic             seq_valid,
  output logic [IDX_W-1:0] cur_idx,
  output logic             issue_strobe,
  output logic             gap_load
);
  sq_state_t        state;
  logic [IDX_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      seq_valid <= 1'b0;
      last_q    <= '0;
      cur_idx   <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (issue_we) begin
            seq_valid <= issue_valid_in;
            last_q    <= issue_last;
          end else if (seq_valid && start_q) begin
            cur_idx <= '0;
            state   <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: state <= SQ_GAP;
        SQ_GAP: begin
          if (gap_expired) begin
            if (cur_idx == last_q) begin
              seq_valid <= 1'b0;
              state     <= SQ_IDLE;
            end else begin
              cur_idx <= cur_idx + 1'b1;
              state   <= SQ_ISSUE;
            end
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy         = (state != SQ_IDLE);
  assign issue_strobe = (state == SQ_ISSUE);
  assign gap_load     = issue_strobe;

  // R3: two strobes are never adjacent
  assert_min_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_strobe |=> !issue_strobe);
  // R5: the valid flag stays set throughout a replay
  assert_busy_has_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> seq_valid);
  // R4: the slot pointer never passes the last index
  assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_idx <= last_q));
  // R9: an issue write during a replay leaves the flag set
  assert_issue_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && issue_we && !(state == SQ_GAP && gap_expired && cur_idx == last_q))
      |=> seq_valid);
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dis_pkg::*;
#(
  parameter int          SLOTS   = 16,
  parameter int          IDX_W   = $clog2(SLOTS),
  parameter logic [31:0] NOP_CMD = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_we,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic             slot_sel,
  input  logic [31:0]      slot_wdata,
  input  logic             issue_we,
  input  logic             issue_valid_in,
  input  logic [IDX_W-1:0] issue_last,
  input  logic             ctl_we,
  input  logic             ctl_start,
  input  logic             ctl_done,
  output logic [31:0]      dram_cmd,
  output logic [10:0]      dram_addr,
  output logic             dram_cmd_strobe,
  output logic             issue_valid,
  output logic             busy,
  output logic             normal_en
);
  logic             start_q, done_q;
  logic [IDX_W-1:0] cur_idx;
  logic [31:0]      rd_cmd, rd_param;
  logic             gap_load, gap_expired, strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (ctl_we) begin
      start_q <= ctl_start;
      done_q  <= ctl_done;
    end
  end

  dis_slot_bank #(.SLOTS(SLOTS), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(slot_we), .wr_idx(slot_idx), .wr_sel(slot_sel), .wr_data(slot_wdata),
    .rd_idx(cur_idx), .rd_cmd(rd_cmd), .rd_param(rd_param)
  );

  dis_gap_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(gap_load), .load_val(rd_param[WORD_W-1:ADDR_W]), .expired(gap_expired)
  );

  dis_replay_ctl #(.IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .issue_we(issue_we), .issue_valid_in(issue_valid_in), .issue_last(issue_last),
    .start_q(start_q), .gap_expired(gap_expired),
    .busy(busy), .seq_valid(issue_valid), .cur_idx(cur_idx),
    .issue_strobe(strobe), .gap_load(gap_load)
  );

  assign dram_cmd_strobe = strobe;
  assign dram_cmd        = strobe ? rd_cmd : NOP_CMD;
  assign dram_addr       = strobe ? rd_param[ADDR_W-1:0] : '0;
  assign normal_en       = start_q & done_q;

  // R7: with no replay running the bus carries only NOPs
  assert_idle_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dram_cmd == NOP_CMD && dram_addr == '0 && !dram_cmd_strobe));
  // R6: a replay never begins without the start bit
  assert_start_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_q));
endmodule

// File: tb/sim_dram_init_seq.sv
module sim_dram_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_we = 0, slot_sel = 0, issue_we = 0, issue_valid_in = 0;
  logic ctl_we = 0, ctl_start = 0, ctl_done = 0;
  logic [3:0]  slot_idx = '0, issue_last = '0;
  logic [31:0] slot_wdata = '0;
  logic [31:0] dram_cmd;
  logic [10:0] dram_addr;
  logic dram_cmd_strobe, issue_valid, busy, normal_en;

  int total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  dram_init_seq u0 (
    .clk(clk), .rst_n(rst_n),
    .slot_we(slot_we), .slot_idx(slot_idx), .slot_sel(slot_sel), .slot_wdata(slot_wdata),
    .issue_we(issue_we), .issue_valid_in(issue_valid_in), .issue_last(issue_last),
    .ctl_we(ctl_we), .ctl_start(ctl_start), .ctl_done(ctl_done),
    .dram_cmd(dram_cmd), .dram_addr(dram_addr), .dram_cmd_strobe(dram_cmd_strobe),
    .issue_valid(issue_valid), .busy(busy), .normal_en(normal_en)
  );

  // power-up list: NOP 400 ns, PREA, EMR2, EMR3, EMR1, MR+DLL reset, PREA, REF, REF, MR, EMR1 OCD dflt, EMR1 OCD exit
  localparam logic [31:0] TBL_CMD [12] = '{
    32'h0000_00A1, 32'h0000_00B2, 32'h0000_00C3, 32'h0000_00C4, 32'h0000_00C5, 32'h2000_00C6,
    32'h0000_00B7, 32'h0000_00D8, 32'h0000_00D9, 32'h3000_00CA, 32'h0C00_00CB, 32'h4000_00CC};
  localparam logic [10:0] TBL_ADDR [12] = '{
    11'h000, 11'h004, 11'h200, 11'h300, 11'h100, 11'h00B,
    11'h004, 11'h000, 11'h000, 11'h00A, 11'h103, 11'h100};
  localparam int TBL_WAIT [12] = '{98, 3, 0, 0, 0, 0, 3, 30, 30, 0, 0, 138};

  logic [31:0] ecmd [16];
  logic [10:0] eaddr [16];
  int          ewait [16];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_slot(input int idx, input bit sel, input logic [31:0] data);
    @(negedge clk);
    slot_we = 1; slot_idx = 4'(idx); slot_sel = sel; slot_wdata = data;
    @(negedge clk);
    slot_we = 0;
  endtask

  task automatic load_slot(input int idx, input logic [31:0] cmd, input logic [10:0] addr,
                           input int w);
    wr_slot(idx, 1'b0, cmd);
    wr_slot(idx, 1'b1, {21'(w), addr});
    ecmd[idx] = cmd; eaddr[idx] = addr; ewait[idx] = w;
  endtask

  task automatic wr_issue(input bit v, input int last);
    @(negedge clk);
    issue_we = 1; issue_valid_in = v; issue_last = 4'(last);
    @(negedge clk);
    issue_we = 0;
  endtask

  task automatic wr_ctl(input bit s, input bit d);
    @(negedge clk);
    ctl_we = 1; ctl_start = s; ctl_done = d;
    @(negedge clk);
    ctl_we = 0;
  endtask

  // follows one replay, comparing each strobe against ecmd/eaddr/ewait
  task automatic run_seq(input int last, input bit inject, input string req);
    int k = 0, prev = 0, cyc = 0, nopbad = 0;
    bit fin = 0;
    while (!fin && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (inject && cyc == 4) begin
        issue_we = 1; issue_valid_in = 0; issue_last = 4'd0;
      end else if (inject) begin
        issue_we = 0;
      end
      if (inject && cyc == 6)
        chk(issue_valid === 1'b1, "R9", "valid after ignored write", 64'(issue_valid), 1);
      if (dram_cmd_strobe) begin
        if (k <= last) begin
          chk(dram_cmd === ecmd[k], req, $sformatf("cmd slot %0d", k), 64'(dram_cmd), 64'(ecmd[k]));
          chk(dram_addr === eaddr[k], "R3", $sformatf("addr slot %0d", k), 64'(dram_addr), 64'(eaddr[k]));
          if (k > 0)
            chk(cyc - prev == ewait[k-1] + 2, "R3", $sformatf("spacing before slot %0d", k),
                64'(cyc - prev), 64'(ewait[k-1] + 2));
        end
        prev = cyc;
        k++;
      end else begin
        if (dram_cmd !== 32'h0 || dram_addr !== 11'h0) nopbad++;
        if (k > 0 && !issue_valid) begin
          chk(cyc - prev == ewait[last] + 2, "R5", "valid clear delay", 64'(cyc - prev),
              64'(ewait[last] + 2));
          chk(busy === 1'b0, "R5", "busy falls with valid", 64'(busy), 0);
          fin = 1;
        end
      end
    end
    issue_we = 0;
    chk(k == last + 1, "R4", "strobe count", 64'(k), 64'(last + 1));
    chk(nopbad == 0, "R7", "non-NOP cycles between strobes", 64'(nopbad), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1", "busy", 64'(busy), 0);
    chk(issue_valid === 1'b0, "R1", "issue_valid", 64'(issue_valid), 0);
    chk(normal_en === 1'b0, "R1", "normal_en", 64'(normal_en), 0);
    chk(dram_cmd === 32'h0 && dram_addr === 11'h0 && !dram_cmd_strobe, "R1", "bus idle",
        64'(dram_cmd), 0);
    rst_n = 1;

    // R10 table walk: load the power-up list
    for (int i = 0; i < 12; i++) load_slot(i, TBL_CMD[i], TBL_ADDR[i], TBL_WAIT[i]);

    // R6: valid without start issues nothing
    wr_issue(1'b1, 11);
    seen = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (dram_cmd_strobe || busy) seen++;
    end
    chk(seen == 0, "R6", "activity without start", 64'(seen), 0);
    chk(issue_valid === 1'b1, "R6", "valid held pending start", 64'(issue_valid), 1);

    wr_ctl(1'b1, 1'b0);
    run_seq(11, 1'b0, "R10");

    // R8 normal enable gating
    chk(normal_en === 1'b0, "R8", "start only", 64'(normal_en), 0);
    wr_ctl(1'b1, 1'b1);
    chk(normal_en === 1'b1, "R8", "start and done", 64'(normal_en), 1);
    wr_ctl(1'b0, 1'b1);
    chk(normal_en === 1'b0, "R8", "done only", 64'(normal_en), 0);
    wr_ctl(1'b1, 1'b0);

    // R9: issue write mid-replay is ignored
    load_slot(0, 32'h0000_1111, 11'h055, 5);
    load_slot(1, 32'h0000_2222, 11'h066, 1);
    load_slot(2, 32'h0000_3333, 11'h077, 4);
    wr_issue(1'b1, 2);
    run_seq(2, 1'b1, "R9");

    // R2: overwrite the command word only; parameter word is held
    wr_slot(0, 1'b0, 32'h0000_ABCD);
    ecmd[0] = 32'h0000_ABCD;
    wr_issue(1'b1, 0);
    run_seq(0, 1'b0, "R2");

    // R3 minimum spacing with W=0, R4 two-slot list
    load_slot(0, 32'h0000_5A5A, 11'h7FF, 0);
    load_slot(1, 32'h0000_A5A5, 11'h001, 0);
    wr_issue(1'b1, 1);
    run_seq(1, 1'b0, "R2");
    // R2: slot 2 untouched since its last write
    wr_issue(1'b1, 2);
    run_seq(2, 1'b0, "R2");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule